// File: doc/BRIEF.md
# Pipelined Signed Multiply-Accumulate Unit

This block forms the sum of products of two signed 64-bit operand streams. The operands arrive one pair per clock. A start pulse opens a run: it clears the running sum, and the operand pair that arrives with it is the first term. The block then takes one pair on every cycle. The run closes when a stop request is seen or when the term limit (256 by default) is reached.

Each accepted pair passes through three stages: an operand register, a product register after the multiplier, and a wide accumulator. The 128-bit product is sign-extended to the full 384-bit width before it is added. At that width even 256 products of the most negative operand values cannot overflow.

Capture ends before the last term has reached the accumulator. The control therefore lets the two pipeline registers empty before it raises the done flag. While done is high, the complete sum is presented in parallel and holds until the next start. A start during a run drops that run together with any of its terms still in the pipeline.

Top module: `sop_mac`

## Requirements
- R1: While reset is held and after it is released, `run_done` is 0 and `sum_q` is all zeros until a run completes.
- R2: A cycle with `run_start` high clears `sum_q` to zero at that clock edge. The operand pair sampled in that same cycle is the first term of the new run.
- R3: When `run_done` is high, `sum_q` equals the sum over all captured terms of `op_a`×`op_b`. The operands are read as two's-complement, and the sum is exact in 384-bit two's-complement with no wrap, even for 256 products of (-2^63)×(-2^63).
- R4: `run_stop` high, without `run_start`, in a cycle of a run ends capture at that edge. The pair sampled with the stop, and every later pair, do not enter the sum.
- R5: A run captures at most 256 terms. After the 256th pair has been sampled, further pairs are ignored and the run ends without any stop request.
- R6: `run_done` rises on the second clock edge after the edge that ended capture, which is either the edge that sampled the stop or the edge that sampled the 256th pair. It is low at the first edge.
- R7: Once high, `run_done` stays high and `sum_q` keeps its value until a `run_start` is sampled. `run_done` is 0 after that edge.
- R8: A `run_start` during a run abandons that run. No term of the abandoned run, including terms still in the pipeline, appears in the new sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_start | input | 1 | Opens a run; the pair sampled with it is term one |
| run_stop | input | 1 | Ends capture of the current run |
| op_a | input | 64 | First operand, signed two's-complement |
| op_b | input | 64 | Second operand, signed two's-complement |
| run_done | output | 1 | High while the sum of the finished run is valid |
| sum_q | output | 384 | Accumulated signed sum of products |

## Verification
Single-term runs use operand pairs that cover every sign combination, the extreme values +(2^63-1) and -2^63, zero, and ordinary mixed values. These show whether the product is signed and whether it is sign-extended correctly into the wide sum. Multi-term runs use varied values. They show whether the first term is lost, and whether pairs sampled with or after a stop leak into the sum. A restart in the middle of a run shows whether terms still in the pipeline are flushed. A run of 256 most-negative products with no stop checks both the term limit and the absence of overflow, and pins down the exact cycle on which done rises.

// File: rtl/sop_mac_pkg.sv
package sop_mac_pkg;

  // Run sequencing states
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CAPT  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } mac_state_e;

  // Register stages between operand capture and the accumulator
  localparam int unsigned PIPE_DEPTH = 2;

endpackage

// File: rtl/mac_opnd_stage.sv
module mac_opnd_stage #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic         vld_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_o   <= '0;
      b_o   <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= cap_i;
      if (cap_i) begin
        a_o <= a_i;
        b_o <= b_i;
      end
    end
  end

endmodule

// File: rtl/mac_prod_stage.sv
module mac_prod_stage #(
  parameter int unsigned W = 64,
  localparam int unsigned PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          vld_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  output logic [PW-1:0] prod_o,
  output logic          vld_o
);

  // Full-width signed product of two W-bit two's-complement values
  function automatic logic [PW-1:0] mul_s(input logic [W-1:0] x, input logic [W-1:0] y);
    logic signed [PW-1:0] sx;
    logic signed [PW-1:0] sy;
    sx = PW'($signed(x));
    sy = PW'($signed(y));
    return PW'(sx * sy);
  endfunction

  logic [PW-1:0] prod_c;
  assign prod_c = mul_s(a_i, b_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= vld_i && !flush_i;
      if (vld_i) prod_o <= prod_c;
    end
  end

endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int unsigned PW = 128,
  parameter int unsigned QW = 384
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          add_i,
  input  logic [PW-1:0] prod_i,
  output logic [QW-1:0] acc_o
);

  // Sign-extend a product to the accumulator width
  function automatic logic [QW-1:0] widen(input logic [PW-1:0] p);
    return {{(QW - PW){p[PW-1]}}, p};
  endfunction

  logic [QW-1:0] term_ext;
  assign term_ext = widen(prod_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_o <= '0;
    else if (clr_i)  acc_o <= '0;
    else if (add_i)  acc_o <= acc_o + term_ext;
  end

  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (acc_o == '0)); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (add_i && !clr_i && (acc_o[QW-1] == term_ext[QW-1]))
      |=> (acc_o[QW-1] == $past(acc_o[QW-1]))); // R3

endmodule

// File: rtl/mac_run_ctrl.sv
module mac_run_ctrl
  import sop_mac_pkg::*;
#(
  parameter int unsigned MAX_TERMS = 256,
  localparam int unsigned CW = $clog2(MAX_TERMS + 1),
  localparam int unsigned DW = (PIPE_DEPTH > 1) ? $clog2(PIPE_DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          pipe_busy_i,
  output logic          cap_o,
  output logic          done_o,
  output logic [CW-1:0] terms_o
);

  localparam logic [DW-1:0] DR_LOAD = DW'(PIPE_DEPTH - 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MAX_TERMS);

  mac_state_e    st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] dr_q, dr_n;
  logic          capture_end;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    dr_n  = dr_q;
    if (start_i) begin
      st_n  = ST_CAPT;
      cnt_n = CW'(1);
      if (cnt_n == CNT_MAX) begin
        st_n = ST_DRAIN;
        dr_n = DR_LOAD;
      end
    end else begin
      case (st_q)
        ST_CAPT: begin
          if (stop_i) begin
            st_n = ST_DRAIN;
            dr_n = DR_LOAD;
          end else begin
            cnt_n = cnt_q + CW'(1);
            if (cnt_n == CNT_MAX) begin
              st_n = ST_DRAIN;
              dr_n = DR_LOAD;
            end
          end
        end
        ST_DRAIN: begin
          if (dr_q == '0) st_n = ST_DONE;
          else            dr_n = dr_q - DW'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      dr_q  <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      dr_q  <= dr_n;
    end
  end

  assign capture_end = (st_n == ST_DRAIN) && (st_q != ST_DRAIN);
  assign cap_o       = start_i || ((st_q == ST_CAPT) && !stop_i);
  assign done_o      = (st_q == ST_DONE);
  assign terms_o     = cnt_q;

  AST_TERM_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX); // R5

  AST_DRAIN_FOLLOWS_END: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_end && !start_i) |=> !done_o); // R6

  AST_DONE_PIPE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !pipe_busy_i); // R6

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o); // R7

  AST_START_DROPS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !done_o); // R7

endmodule

// File: rtl/sop_mac.sv
module sop_mac #(
  parameter int unsigned W         = 64,
  parameter int unsigned QW        = 384,
  parameter int unsigned MAX_TERMS = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_start,
  input  logic          run_stop,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  output logic          run_done,
  output logic [QW-1:0] sum_q
);

  localparam int unsigned PW = 2 * W;
  localparam int unsigned CW = $clog2(MAX_TERMS + 1);

  logic          cap_en;
  logic [W-1:0]  a_r, b_r;
  logic          opnd_vld;
  logic [PW-1:0] prod_r;
  logic          prod_vld;
  logic          pipe_busy;
  logic [CW-1:0] term_cnt;

  assign pipe_busy = opnd_vld || prod_vld;

  mac_run_ctrl #(.MAX_TERMS(MAX_TERMS)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (run_start),
    .stop_i      (run_stop),
    .pipe_busy_i (pipe_busy),
    .cap_o       (cap_en),
    .done_o      (run_done),
    .terms_o     (term_cnt)
  );

  mac_opnd_stage #(.W(W)) u_opnd (
    .clk   (clk),
    .rst_n (rst_n),
    .cap_i (cap_en),
    .a_i   (op_a),
    .b_i   (op_b),
    .a_o   (a_r),
    .b_o   (b_r),
    .vld_o (opnd_vld)
  );

  mac_prod_stage #(.W(W)) u_prod (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (run_start),
    .vld_i   (opnd_vld),
    .a_i     (a_r),
    .b_i     (b_r),
    .prod_o  (prod_r),
    .vld_o   (prod_vld)
  );

  mac_accum #(.PW(PW), .QW(QW)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (run_start),
    .add_i  (prod_vld),
    .prod_i (prod_r),
    .acc_o  (sum_q)
  );

  AST_STOP_HALTS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_stop && !run_start) |=> !opnd_vld); // R4

  AST_Q_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_done && !run_start) |=> $stable(sum_q)); // R7

  AST_RESTART_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> !prod_vld); // R8

  AST_TERMS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> (term_cnt != '0)); // R2

endmodule

// File: tb/sim_sop_mac.sv
module sim_sop_mac;

  localparam int W  = 64;
  localparam int QW = 384;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          stop = 1'b0;
  logic [W-1:0]  a = '0;
  logic [W-1:0]  b = '0;
  logic          done;
  logic [QW-1:0] q;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  sop_mac u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_start (start),
    .run_stop  (stop),
    .op_a      (a),
    .op_b      (b),
    .run_done  (done),
    .sum_q     (q)
  );

  localparam logic [W-1:0] TA [8] = '{
    64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF,
    64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'd0, 64'h0123_4567_89AB_CDEF };
  localparam logic [W-1:0] TB [8] = '{
    64'd1, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF,
    64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'hDEAD_BEEF_0BAD_F00D, 64'hFEDC_BA98_7654_3211 };

  function automatic logic [QW-1:0] ref_mul(input logic [W-1:0] x, input logic [W-1:0] y);
    logic signed [QW-1:0] ex;
    logic signed [QW-1:0] ey;
    ex = {{(QW - W){x[W-1]}}, x};
    ey = {{(QW - W){y[W-1]}}, y};
    return ex * ey;
  endfunction

  function automatic logic [W-1:0] gen_a(input int k);
    return 64'(k + 3) * 64'h9E37_79B9_7F4A_7C15;
  endfunction

  function automatic logic [W-1:0] gen_b(input int k);
    return 64'(k + 11) * 64'hC2B2_AE3D_27D4_EB4F;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic put(input logic [W-1:0] x, input logic [W-1:0] y, input logic s, input logic p);
    a = x; b = y; start = s; stop = p;
    tick();
  endtask

  task automatic chk(input string req, input logic [QW-1:0] act, input logic [QW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [QW-1:0] exp;
    logic [QW-1:0] held;

    // R1: reset state
    tick(); tick();
    chk("R1 done in reset", QW'(done), QW'(0));
    chk("R1 sum in reset", q, '0);
    rst_n = 1'b1;
    tick();
    chk("R1 done after reset", QW'(done), QW'(0));
    chk("R1 sum after reset", q, '0);

    // Table: single-term runs, done timing and signed product
    for (int i = 0; i < 8; i++) begin
      exp = ref_mul(TA[i], TB[i]);
      put(TA[i], TB[i], 1'b1, 1'b0);
      chk("R2 cleared at start edge", q, '0);
      put(64'h5555, 64'h3333, 1'b0, 1'b1);           // stop edge, pair ignored
      put(64'h7777, 64'h1111, 1'b0, 1'b0);
      chk("R6 done low one edge after end", QW'(done), QW'(0));
      put(64'h2222, 64'h4444, 1'b0, 1'b0);
      chk("R6 done high two edges after end", QW'(done), QW'(1));
      chk("R3 single product", q, exp);
    end

    // R4: multi-term run, pair with stop and later pairs ignored
    exp = '0;
    for (int k = 0; k < 5; k++) begin
      put(gen_a(k), gen_b(k), (k == 0), 1'b0);
      exp = exp + ref_mul(gen_a(k), gen_b(k));
    end
    put(64'd5, 64'd7, 1'b0, 1'b1);
    for (int k = 0; k < 4; k++) put(gen_a(k + 40), gen_b(k + 40), 1'b0, 1'b0);
    chk("R4 done after stopped run", QW'(done), QW'(1));
    chk("R4 sum excludes stop and later pairs", q, exp);

    // R7: hold until start
    held = q;
    for (int k = 0; k < 3; k++) put(gen_a(k + 60), gen_b(k + 60), 1'b0, (k == 1));
    chk("R7 done held", QW'(done), QW'(1));
    chk("R7 sum held", q, held);

    // R8: start a run, abandon it mid-flight
    put(gen_a(70), gen_b(70), 1'b1, 1'b0);
    chk("R7 done cleared by start", QW'(done), QW'(0));
    for (int k = 71; k < 74; k++) put(gen_a(k), gen_b(k), 1'b0, 1'b0);
    exp = '0;
    for (int k = 80; k < 83; k++) begin
      put(gen_a(k), gen_b(k), (k == 80), 1'b0);
      exp = exp + ref_mul(gen_a(k), gen_b(k));
    end
    put(64'd9, 64'd9, 1'b0, 1'b1);
    put(64'd1, 64'd1, 1'b0, 1'b0);
    put(64'd1, 64'd1, 1'b0, 1'b0);
    chk("R8 done after restarted run", QW'(done), QW'(1));
    chk("R8 sum holds only new run", q, exp);

    // R5: 256 most-negative products, no stop
    put(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1, 1'b0);
    for (int k = 1; k < 256; k++)
      put(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 1'b0);
    put(64'd1, 64'd1, 1'b0, 1'b0);
    chk("R6 done low one edge after cap", QW'(done), QW'(0));
    put(64'd1, 64'd1, 1'b0, 1'b0);
    exp = '0;
    exp[134] = 1'b1;
    chk("R5 done after 256 terms", QW'(done), QW'(1));
    chk("R3 worst-case sum no overflow", q, exp);
    for (int k = 0; k < 3; k++) put(64'h8000_0000_0000_0000, 64'd3, 1'b0, 1'b0);
    chk("R5 pairs after cap ignored", q, exp);
    chk("R7 done still held", QW'(done), QW'(1));

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule